// File: doc/BRIEF.md
# Three-Wire Serial Bus Target

This block is the target end of a three-wire serial link: an active-low select, a bus clock driven by the host, and one data line that changes direction within a transfer. Each transfer is a 9-bit header followed by a 16-bit data word. The header holds a device address, a read flag and a register index. The block turns each transfer into a single access on a plain parallel register port. A write is committed as a one-cycle write strobe once the last data bit is in. A read raises a one-cycle read strobe right after the header, and the returned word is then shifted out on the data line.

All three bus inputs are brought into the system clock through two-flop synchronisers. Bus clock rising edges are found in the system-clock domain, so the bus clock must run well below the system clock. A falling select realigns the bit counter to a new header. Transfers may also follow one another with select held low. A transfer whose address differs from the `TARGET_ADDR` parameter still runs through the bit counter, but it produces no strobe and the data output stays released.

Top module: `tw_serial_target`

## Requirements
- R1: After reset the strobes, `reg_wdata`, `reg_addr`, `bus_dout` and `bus_doe` are all 0, and the block waits for a 9-bit header.
- R2: A bit is taken or driven only on a rising bus clock edge seen while select is low. Edges seen while select is high change nothing.
- R3: A falling select discards any partial transfer, clears the shift register and releases the data output. The next 9 rising edges form a header.
- R4: Header bits arrive MSB first. Bits 8:6 are the device address, bit 5 is the read flag (1 = read, 0 = write) and bits 4:0 are the register index, presented on `reg_addr`.
- R5: For a matched read, `reg_rd` pulses for one system cycle right after the 9th header bit. `reg_rdata` is captured in that cycle.
- R6: A matched read drives the captured word on `bus_dout` MSB first, one bit per rising edge. `bus_doe` is high from header completion until the first rising edge after the 16th bit, or until select goes high.
- R7: For a matched write, 16 bits are shifted in MSB first. `reg_wr` pulses for one cycle with `reg_wdata` and `reg_addr` only after the 16th bit.
- R8: After the data phase the block returns to the header phase, so transfers can follow one another without toggling select.
- R9: A transfer whose address differs from `TARGET_ADDR` raises no strobe, leaves `bus_doe` low and keeps `bus_dout` at 0.
- R10: A strobe caused by a bus clock edge appears 3 system-clock edges after the bus clock pin rises: two synchroniser stages plus the action register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_clk | input | 1 | Bus clock from the host |
| bus_din | input | 1 | Bus data from the host |
| bus_dout | output | 1 | Bus data to the host during reads |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| reg_addr | output | REG_W | Register index of the current access |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W | Read data, sampled while `reg_rd` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | DATA_W | Write data, valid with `reg_wr` |

## Verification
The bench changes bus pins only on falling system-clock edges. It then waits three falling edges after each bus clock rise before it reads `bus_dout` and `bus_doe`, because every result lands on the third rising system edge after the pin moves. One directed test samples `reg_wr` after the first, second and third rising edge that follows the last write bit. It expects the strobe only at the third, which pins the latency exactly. Strobes are tallied on falling edges by a register model in the bench. Each transfer then compares the tallies and the returned read words against expected values computed from the requirements.

// File: rtl/tw_serial_target.sv
module tw_serial_target #(
  parameter int ADDR_W = 3,
  parameter int REG_W = 5,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_n,
  input  logic              bus_clk,
  input  logic              bus_din,
  output logic              bus_dout,
  output logic              bus_doe,
  output logic [REG_W-1:0]  reg_addr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata
);
  localparam int HDR_W = ADDR_W + 1 + REG_W;
  localparam int SH_W  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
  localparam int CNT_W = $clog2(SH_W);

  logic [1:0] sel_sy, clk_sy, din_sy;
  logic       sel_d, clk_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_sy <= 2'b11;
      clk_sy <= 2'b00;
      din_sy <= 2'b00;
      sel_d  <= 1'b1;
      clk_d  <= 1'b0;
    end else begin
      sel_sy <= {sel_sy[0], bus_sel_n};
      clk_sy <= {clk_sy[0], bus_clk};
      din_sy <= {din_sy[0], bus_din};
      sel_d  <= sel_sy[1];
      clk_d  <= clk_sy[1];
    end

  logic sel_hi, rise, sel_fall, bit_in;
  assign sel_hi   = sel_sy[1];
  assign bit_in   = din_sy[1];
  assign rise     = clk_sy[1] & ~clk_d & ~sel_hi;
  assign sel_fall = ~sel_hi & sel_d;

  logic             in_data, is_rd, hit;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  shreg;
  logic [HDR_W-1:0] hdr_next;
  logic [DATA_W-1:0] word_next;
  logic             hdr_hit;

  assign hdr_next  = {shreg[HDR_W-2:0], bit_in};
  assign word_next = {shreg[DATA_W-2:0], bit_in};
  assign hdr_hit   = (hdr_next[HDR_W-1 -: ADDR_W] == TARGET_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_data   <= 1'b0;
      is_rd     <= 1'b0;
      hit       <= 1'b0;
      cnt       <= CNT_W'(HDR_W - 1);
      shreg     <= '0;
      reg_addr  <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      bus_dout  <= 1'b0;
      bus_doe   <= 1'b0;
    end else begin
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      if (reg_rd) shreg <= SH_W'(reg_rdata);
      if (sel_hi) begin
        bus_doe  <= 1'b0;
        bus_dout <= 1'b0;
      end
      if (sel_fall) begin
        in_data  <= 1'b0;
        cnt      <= CNT_W'(HDR_W - 1);
        shreg    <= '0;
        bus_doe  <= 1'b0;
        bus_dout <= 1'b0;
      end else if (rise) begin
        if (!in_data) begin
          bus_dout <= 1'b0;
          if (cnt == '0) begin
            in_data <= 1'b1;
            cnt     <= CNT_W'(DATA_W - 1);
            shreg   <= '0;
            is_rd   <= hdr_next[REG_W];
            hit     <= hdr_hit;
            if (hdr_hit) reg_addr <= hdr_next[REG_W-1:0];
            reg_rd  <= hdr_hit & hdr_next[REG_W];
            bus_doe <= hdr_hit & hdr_next[REG_W];
          end else begin
            shreg   <= SH_W'(hdr_next);
            cnt     <= cnt - 1'b1;
            bus_doe <= 1'b0;
          end
        end else begin
          if (is_rd) begin
            bus_dout <= hit & shreg[DATA_W-1];
            shreg    <= {shreg[SH_W-2:0], 1'b0};
          end else begin
            shreg    <= SH_W'(word_next);
          end
          if (cnt == '0) begin
            in_data <= 1'b0;
            cnt     <= CNT_W'(HDR_W - 1);
            if (!is_rd && hit) begin
              reg_wr    <= 1'b1;
              reg_wdata <= word_next;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
endmodule

// File: rtl/tw_serial_target_chk.sv
module tw_serial_target_chk #(
  parameter int HDR_W = 9,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             sel_fall,
  input logic             in_data,
  input logic [CNT_W-1:0] cnt,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic             bus_doe,
  input logic             bus_dout
);
  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  assert_wr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
  assert_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe |-> !bus_dout);
  assert_resync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> (!in_data && cnt == CNT_W'(HDR_W - 1) && !bus_doe));
  assert_edge_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !sel_fall) |=> ($stable(cnt) && $stable(in_data)));
  assert_wr_after_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_wr) |-> $past(rise));
endmodule

bind tw_serial_target tw_serial_target_chk #(.HDR_W(HDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .sel_fall(sel_fall),
  .in_data(in_data), .cnt(cnt), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .bus_doe(bus_doe), .bus_dout(bus_dout)
);

// File: tb/tb_tw_serial_target.sv
`timescale 1ns/1ps
module tb_tw_serial_target;
  logic clk = 0, rst_n = 0;
  logic bus_sel_n = 1, bus_clk = 0, bus_din = 0;
  logic bus_dout, bus_doe, reg_rd, reg_wr;
  logic [4:0] reg_addr;
  logic [15:0] reg_rdata, reg_wdata;

  always #2.5 clk = ~clk;

  tw_serial_target dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_clk(bus_clk),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

  logic [15:0] dev_mem [32];
  logic [15:0] exp_mem [32];
  int wr_cnt = 0, rd_cnt = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  assign reg_rdata = dev_mem[reg_addr];

  initial for (int i = 0; i < 32; i++) begin dev_mem[i] = '0; exp_mem[i] = '0; end

  always @(negedge clk) begin
    if (reg_wr) begin dev_mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
    if (reg_rd) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic s_dout, output logic s_doe);
    @(negedge clk) bus_din = b;
    @(negedge clk) bus_clk = 1;
    repeat (3) @(negedge clk);
    s_dout = bus_dout;
    s_doe  = bus_doe;
    bus_clk = 0;
    @(negedge clk);
  endtask

  task automatic xfer(input logic [2:0] a, input logic rd, input logic [4:0] r,
                      input logic [15:0] d, output logic [15:0] q, output int doe_bad);
    logic [8:0] h;
    logic so, se;
    h = {a, rd, r};
    doe_bad = 0;
    q = '0;
    for (int i = 8; i >= 0; i--) pulse(h[i], so, se);
    for (int i = 15; i >= 0; i--) begin
      pulse(d[i], so, se);
      q[i] = so;
      if (se !== (rd && a == 3'd1)) doe_bad++;
      if (!se && so) doe_bad++;
    end
  endtask

  task automatic sel_low;
    @(negedge clk) bus_sel_n = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sel_high;
    @(negedge clk) bus_sel_n = 1;
    repeat (4) @(negedge clk);
  endtask

  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {3'd1, 1'b0, 5'd3,  16'hA5C3},
    {3'd1, 1'b0, 5'd31, 16'hFFFF},
    {3'd1, 1'b0, 5'd0,  16'h0001},
    {3'd1, 1'b1, 5'd3,  16'h0000},
    {3'd1, 1'b1, 5'd31, 16'h0000},
    {3'd2, 1'b0, 5'd3,  16'h1234},
    {3'd1, 1'b1, 5'd3,  16'h0000},
    {3'd0, 1'b0, 5'd0,  16'hBEEF},
    {3'd1, 1'b1, 5'd0,  16'h0000},
    {3'd1, 1'b0, 5'd16, 16'h8000},
    {3'd1, 1'b1, 5'd16, 16'h0000},
    {3'd7, 1'b1, 5'd3,  16'h0000},
    {3'd1, 1'b1, 5'd7,  16'h0000},
    {3'd5, 1'b0, 5'd31, 16'h0F0F}
  };

  initial begin
    repeat (500000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    int bad, w0, r0;
    logic so, se;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset strobes", {reg_rd, reg_wr, bus_doe, bus_dout}, 0);
    check("R1 reset wdata/addr", {reg_wdata, reg_addr}, 0);

    sel_low;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] a; logic rd; logic [4:0] r; logic [15:0] d;
      logic hit;
      {a, rd, r, d} = VEC[i];
      hit = (a == 3'd1);
      w0 = wr_cnt; r0 = rd_cnt;
      xfer(a, rd, r, d, q, bad);
      @(negedge clk);
      if (rd) begin
        check(hit ? "R6 read word" : "R9 unmatched read dout", q, hit ? exp_mem[r] : 16'h0);
        check("R5 read strobe count", rd_cnt - r0, hit ? 1 : 0);
      end else begin
        if (hit) exp_mem[r] = d;
        check("R7 write strobe count", wr_cnt - w0, hit ? 1 : 0);
        check("R7/R9 register contents", dev_mem[r], exp_mem[r]);
      end
      check("R6/R9 output enable", bad, 0);
    end
    check("R8 back-to-back total writes", wr_cnt, 4);

    pulse(1'b0, so, se);
    check("R6 enable drops after next edge", se, 0);
    sel_high;

    // R2: edges with select high are ignored
    w0 = wr_cnt;
    begin
      logic [24:0] v;
      v = {3'd1, 1'b0, 5'd3, 16'h5555};
      for (int i = 24; i >= 0; i--) pulse(v[i], so, se);
    end
    check("R2 no write while deselected", wr_cnt - w0, 0);
    sel_low;
    xfer(3'd1, 1'b1, 5'd3, 16'h0, q, bad);
    check("R2 register unchanged", q, exp_mem[3]);
    @(negedge clk);
    check("R6 enable held after last bit", bus_doe, 1);
    sel_high;
    check("R6 enable drops on select high", bus_doe, 0);

    // R3: partial header then resync
    sel_low;
    for (int i = 0; i < 5; i++) pulse(1'b1, so, se);
    sel_high;
    sel_low;
    w0 = wr_cnt;
    xfer(3'd1, 1'b0, 5'd9, 16'h3C3C, q, bad);
    @(negedge clk);
    exp_mem[9] = 16'h3C3C;
    check("R3 resync write count", wr_cnt - w0, 1);
    check("R3/R4 resync write lands", dev_mem[9], 16'h3C3C);

    // R10: exact strobe latency on last write bit, R4 field mapping
    begin
      logic [24:0] v;
      v = {3'd1, 1'b0, 5'd21, 16'hC001};
      for (int i = 24; i >= 1; i--) pulse(v[i], so, se);
      @(negedge clk) bus_din = v[0];
      @(negedge clk) bus_clk = 1;
      @(negedge clk) check("R10 no strobe after 1 edge", reg_wr, 0);
      @(negedge clk) check("R10 no strobe after 2 edges", reg_wr, 0);
      @(negedge clk) check("R10 strobe after 3 edges", reg_wr, 1);
      check("R4 register index", reg_addr, 5'd21);
      check("R7 write data", reg_wdata, 16'hC001);
      bus_clk = 0;
      @(negedge clk);
      check("R7 strobe one cycle", reg_wr, 0);
    end
    sel_high;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule